// File: doc/BRIEF.md
# Serial FPGA Bitstream Loader

This block configures a serially loaded FPGA from a stream of bitstream bytes. A start request makes it pulse the active-low program line. It then takes bytes one at a time over a valid/ready handshake and shifts each one out on a single data line, most significant bit first, against a configuration clock that it drives itself. The byte marked last ends the data phase. The block then issues a fixed run of start-up clocks and waits a short settle interval. After that it samples the device's done/initialised status.

The result is held on two outputs, a completion flag and an error flag, until the next start request. At completion the block also raises a request to hold the downstream audio output muted. The block does not store the bitstream, and it does not contain the mute register. Every interval is a parameter counted in system clocks: the program pulse, each half of a configuration clock period, and the settle wait.

Top module: `fpga_cfg_loader`

## Requirements
- R1: `prog_n` is high whenever the block is idle. A start request taken while idle drives `prog_n` low for exactly `PROG_LOW_CYC` clock cycles. `prog_n` is high again before the first configuration clock edge, and `cfg_clk` stays low while `prog_n` is low.
- R2: Every accepted byte appears on `cfg_dout` most significant bit first. Exactly one rising edge of `cfg_clk` occurs per bit. Bytes go out in the order they were accepted.
- R3: For every bit, `cfg_clk` is first low for `PHASE_CYC` cycles with the bit already on `cfg_dout`, then high for `PHASE_CYC` cycles. `cfg_dout` does not change while `cfg_clk` is high.
- R4: After the eighth bit of the byte accepted with `in_last` = 1, exactly `STARTUP_CLKS` further rising edges of `cfg_clk` follow, with `cfg_dout` = 0 at each of them.
- R5: `SETTLE_CYC` cycles after the last start-up clock, the synchronised `cfg_done_in` is sampled. At that point `load_done` becomes 1 and `load_err` becomes 1 exactly when the sampled status is low.
- R6: `mute_req` rises together with `load_done` and stays high until the next accepted start.
- R7: `in_ready` is high only while the block waits for the next byte. A byte is taken on a cycle with both `in_valid` and `in_ready` high. Cycles with `in_valid` low only delay the transfer.
- R8: `load_done` and `load_err` hold their values while idle. An accepted start clears both on the clock edge that takes it.
- R9: A start request while `busy` is high has no effect: no further program pulse occurs, and the load in progress completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a configuration load (taken only while idle) |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | `in_data` and `in_last` are valid |
| in_last | input | 1 | Marks the final bitstream byte |
| in_ready | output | 1 | Block will accept a byte this cycle |
| prog_n | output | 1 | Active-low program line to the FPGA |
| cfg_clk | output | 1 | Configuration clock; the device samples on its rising edge |
| cfg_dout | output | 1 | Configuration data bit |
| cfg_done_in | input | 1 | Done/initialised status from the FPGA (asynchronous) |
| busy | output | 1 | A load sequence is in progress |
| load_done | output | 1 | Last load finished and its status was sampled |
| load_err | output | 1 | Last load finished with the status input low |
| mute_req | output | 1 | Request to hold the output mute asserted |

## Verification
The bench records `cfg_dout` at every rising edge of `cfg_clk` and compares the complete record with the expected MSB-first bit stream followed by the zero-data start-up run. A design that shifted LSB first, dropped the last byte's final bit, or produced one start-up pulse too many or too few would make that record differ in content or in length. The bench also measures the width of the program pulse and of every clock-high phase, and checks data stability across each high phase. A design that changed data after the rising edge would be caught there. Further tests cover a failing status, which must set the error flag, and a start pulsed mid-load, which must not re-pulse the program line. After a failed load, the next load must clear the error flag.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_FETCH,
        S_BITLO,
        S_BITHI,
        S_STARTLO,
        S_STARTHI,
        S_SETTLE
    } ld_state_e;

    typedef struct packed {
        ld_state_e          st;
        logic [BYTE_W-1:0]  sreg;
        logic [IDX_W-1:0]   bitidx;
        logic               last;
        logic               prog_n;
        logic               cclk;
        logic               dout;
        logic               done;
        logic               err;
        logic               mute;
    } ld_regs_t;

endpackage

// File: rtl/cfg_loader_timer.sv
// Loadable down-counter; zero flags expiry of the loaded interval.
module cfg_loader_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cfg_loader_sync.sv
// Multi-stage synchroniser for the asynchronous status input.
module cfg_loader_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q[STAGES-1];

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int PROG_LOW_CYC = 6,
    parameter int PHASE_CYC    = 2,
    parameter int SETTLE_CYC   = 3,
    parameter int STARTUP_CLKS = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              prog_n,
    output logic              cfg_clk,
    output logic              cfg_dout,
    input  logic              cfg_done_in,
    output logic              busy,
    output logic              load_done,
    output logic              load_err,
    output logic              mute_req
);

    localparam int T_A   = (PROG_LOW_CYC > PHASE_CYC) ? PROG_LOW_CYC : PHASE_CYC;
    localparam int T_MAX = (T_A > SETTLE_CYC) ? T_A : SETTLE_CYC;
    localparam int TW    = $clog2(T_MAX + 1);
    localparam int PW    = $clog2(STARTUP_CLKS + 1);

    localparam logic [TW-1:0]    PROG_LD   = TW'(PROG_LOW_CYC - 1);
    localparam logic [TW-1:0]    PHASE_LD  = TW'(PHASE_CYC - 1);
    localparam logic [TW-1:0]    SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [PW-1:0]    PULSE_LD  = PW'(STARTUP_CLKS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(BYTE_W - 1);

    ld_regs_t        q, n;
    logic            tmr_load, tmr_zero;
    logic [TW-1:0]   tmr_val;
    logic            pls_load, pls_dec, pls_zero;
    logic            done_sync;

    cfg_loader_timer #(.W(TW)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .dec      (1'b1),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cfg_loader_timer #(.W(PW)) u_pulse_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pls_load),
        .dec      (pls_dec),
        .load_val (PULSE_LD),
        .zero     (pls_zero)
    );

    cfg_loader_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cfg_done_in),
        .sync_out (done_sync)
    );

    always_comb begin
        n        = q;
        tmr_load = 1'b0;
        tmr_val  = PHASE_LD;
        pls_load = 1'b0;
        pls_dec  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    n.st     = S_PROG;
                    tmr_load = 1'b1;
                    tmr_val  = PROG_LD;
                    n.done   = 1'b0;
                    n.err    = 1'b0;
                    n.mute   = 1'b0;
                end
            end
            S_PROG: begin
                if (tmr_zero) n.st = S_FETCH;
            end
            S_FETCH: begin
                if (in_valid) begin
                    n.sreg   = in_data;
                    n.last   = in_last;
                    n.bitidx = '0;
                    n.st     = S_BITLO;
                    tmr_load = 1'b1;
                end
            end
            S_BITLO: begin
                if (tmr_zero) begin
                    n.st     = S_BITHI;
                    tmr_load = 1'b1;
                end
            end
            S_BITHI: begin
                if (tmr_zero) begin
                    if (q.bitidx == IDX_LAST) begin
                        if (q.last) begin
                            n.st     = S_STARTLO;
                            tmr_load = 1'b1;
                            pls_load = 1'b1;
                        end else begin
                            n.st = S_FETCH;
                        end
                    end else begin
                        n.bitidx = q.bitidx + 1'b1;
                        n.sreg   = {q.sreg[BYTE_W-2:0], 1'b0};
                        n.st     = S_BITLO;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_STARTLO: begin
                if (tmr_zero) begin
                    n.st     = S_STARTHI;
                    tmr_load = 1'b1;
                end
            end
            S_STARTHI: begin
                if (tmr_zero) begin
                    if (pls_zero) begin
                        n.st     = S_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = SETTLE_LD;
                    end else begin
                        pls_dec  = 1'b1;
                        n.st     = S_STARTLO;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_SETTLE: begin
                if (tmr_zero) begin
                    n.st   = S_IDLE;
                    n.done = 1'b1;
                    n.err  = !done_sync;
                    n.mute = 1'b1;
                end
            end
            default: n.st = S_IDLE;
        endcase
        n.prog_n = (n.st != S_PROG);
        n.cclk   = (n.st == S_BITHI) || (n.st == S_STARTHI);
        n.dout   = ((n.st == S_BITLO) || (n.st == S_BITHI)) ? n.sreg[BYTE_W-1] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, sreg: '0, bitidx: '0, last: 1'b0, prog_n: 1'b1,
                   cclk: 1'b0, dout: 1'b0, done: 1'b0, err: 1'b0, mute: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign in_ready  = (q.st == S_FETCH);
    assign busy      = (q.st != S_IDLE);
    assign prog_n    = q.prog_n;
    assign cfg_clk   = q.cclk;
    assign cfg_dout  = q.dout;
    assign load_done = q.done;
    assign load_err  = q.err;
    assign mute_req  = q.mute;

endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic in_ready,
    input logic prog_n,
    input logic cfg_clk,
    input logic cfg_dout,
    input logic busy,
    input logic load_done,
    input logic load_err,
    input logic mute_req
);

    p_idle_prog_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> prog_n);

    p_prog_no_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> !cfg_clk);

    p_pulse_begins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !prog_n);

    p_data_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> $stable(cfg_dout));

    p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> load_done);

    p_mute_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (mute_req && !busy));

    p_ready_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && prog_n && !cfg_clk));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !start) |=> load_done);

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && prog_n && start) |=> prog_n);

endmodule

bind fpga_cfg_loader cfg_loader_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_ready  (in_ready),
    .prog_n    (prog_n),
    .cfg_clk   (cfg_clk),
    .cfg_dout  (cfg_dout),
    .busy      (busy),
    .load_done (load_done),
    .load_err  (load_err),
    .mute_req  (mute_req)
);

// File: tb/fpga_cfg_loader_tb.sv
`timescale 1ns/1ps
module fpga_cfg_loader_tb;

    localparam int PROG_LOW_CYC = 6;
    localparam int PHASE_CYC    = 2;
    localparam int SETTLE_CYC   = 3;
    localparam int STARTUP_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       prog_n, cfg_clk, cfg_dout;
    logic       cfg_done_in = 1'b0;
    logic       busy, load_done, load_err, mute_req;

    int checks = 0;
    int fails  = 0;

    // monitor state
    int   prog_low, nbits, bad_hi, unstable, viol, hi_run;
    logic prev_clk = 1'b0;
    logic last_dout = 1'b0;
    logic mon_bits [0:1023];

    always #2 clk = ~clk;

    fpga_cfg_loader #(
        .PROG_LOW_CYC (PROG_LOW_CYC),
        .PHASE_CYC    (PHASE_CYC),
        .SETTLE_CYC   (SETTLE_CYC),
        .STARTUP_CLKS (STARTUP_CLKS)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .in_ready    (in_ready),
        .prog_n      (prog_n),
        .cfg_clk     (cfg_clk),
        .cfg_dout    (cfg_dout),
        .cfg_done_in (cfg_done_in),
        .busy        (busy),
        .load_done   (load_done),
        .load_err    (load_err),
        .mute_req    (mute_req)
    );

    always @(negedge clk) begin
        if (!prog_n) prog_low++;
        if (in_ready && !busy) viol++;
        if (cfg_clk && !prev_clk) begin
            if (nbits < 1024) mon_bits[nbits] = cfg_dout;
            nbits++;
            if (cfg_dout !== last_dout) unstable++;
        end
        if (cfg_clk) begin
            hi_run++;
            if (prev_clk && (cfg_dout !== last_dout)) unstable++;
        end
        if (!cfg_clk && prev_clk) begin
            if (hi_run != PHASE_CYC) bad_hi++;
            hi_run = 0;
        end
        prev_clk  = cfg_clk;
        last_dout = cfg_dout;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_monitor();
        @(posedge clk);
        #1;
        prog_low = 0; nbits = 0; bad_hi = 0; unstable = 0; viol = 0; hi_run = 0;
    endtask

    // One full load; each scenario checks its own outcome.
    task automatic run_load(input int nbytes, input int seed, input logic status,
                            input int gap, input bit poke);
        logic [7:0] b [0:15];
        int mism;
        int tail_bad;
        int wait_cnt;
        for (int k = 0; k < nbytes; k++) b[k] = 8'(seed * 29 + k * 71 + 3);
        cfg_done_in = status;
        clear_monitor();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(load_done == 1'b0 && load_err == 1'b0 && mute_req == 1'b0, "R8",
              "done/err/mute cleared by start", int'(load_done), 0);
        for (int k = 0; k < nbytes; k++) begin
            for (int g = 0; g < gap; g++) @(negedge clk);
            in_valid = 1'b1;
            in_data  = b[k];
            in_last  = (k == nbytes - 1);
            if (poke && k == 1) start = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            start    = 1'b0;
        end
        if (poke && nbytes == 1) begin
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        wait_cnt = 0;
        while (busy && wait_cnt < 20000) begin
            @(negedge clk);
            wait_cnt++;
        end
        check(prog_low == PROG_LOW_CYC, poke ? "R9" : "R1",
              "program pulse width", prog_low, PROG_LOW_CYC);
        check(nbits == nbytes * 8 + STARTUP_CLKS, "R4",
              "total cfg clock edges", nbits, nbytes * 8 + STARTUP_CLKS);
        mism = 0;
        for (int k = 0; k < nbytes; k++)
            for (int j = 0; j < 8; j++)
                if (mon_bits[k * 8 + j] !== b[k][7 - j]) mism++;
        check(mism == 0, "R2", "MSB-first bit mismatches", mism, 0);
        tail_bad = 0;
        for (int t = 0; t < STARTUP_CLKS; t++)
            if (mon_bits[nbytes * 8 + t] !== 1'b0) tail_bad++;
        check(tail_bad == 0, "R4", "nonzero start-up data bits", tail_bad, 0);
        check(bad_hi == 0 && unstable == 0, "R3", "phase width/stability faults",
              bad_hi + unstable, 0);
        check(viol == 0, "R7", "ready while idle", viol, 0);
        check(load_done == 1'b1, "R5", "load_done", int'(load_done), 1);
        check(load_err == !status, "R5", "load_err", int'(load_err), int'(!status));
        check(mute_req == 1'b1, "R6", "mute_req at completion", int'(mute_req), 1);
    endtask

    task automatic test_reset();
        check(prog_n == 1'b1 && cfg_clk == 1'b0, "R1", "idle prog_n/cfg_clk",
              int'({prog_n, cfg_clk}), 2);
        check(in_ready == 1'b0 && busy == 1'b0, "R7", "idle ready/busy",
              int'({in_ready, busy}), 0);
        check(load_done == 1'b0 && load_err == 1'b0 && mute_req == 1'b0, "R8",
              "reset flags", int'({load_done, load_err, mute_req}), 0);
    endtask

    task automatic test_hold(input logic exp_err);
        in_valid = 1'b1;
        in_data  = 8'hFF;
        repeat (25) @(negedge clk);
        in_valid = 1'b0;
        check(load_done == 1'b1 && load_err == exp_err, "R8", "flags held while idle",
              int'({load_done, load_err}), int'({1'b1, exp_err}));
        check(mute_req == 1'b1, "R6", "mute held while idle", int'(mute_req), 1);
        check(prog_n == 1'b1 && cfg_clk == 1'b0 && !in_ready, "R7",
              "no activity while idle", int'({prog_n, cfg_clk, in_ready}), 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_load(4, 1, 1'b1, 0, 1'b0);
        run_load(3, 7, 1'b0, 3, 1'b0);
        test_hold(1'b1);
        run_load(5, 12, 1'b1, 1, 1'b1);
        run_load(1, 20, 1'b1, 0, 1'b1);
        test_hold(1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule